// File: doc/BRIEF.md
# Instruction Prefetch Queue

This unit sits on the bus side of a 16-bit segmented processor and keeps a small byte queue of instruction code filled ahead of the execution side. It forms each fetch address by shifting a code segment value left by four bits and adding a 16-bit instruction pointer. It then requests one memory word per fetch over a simple request/acknowledge port and places the returned bytes into a six-entry queue. The consumer drains the queue one byte at a time through a valid/ready stream while further fetches proceed.

A control transfer (jump, call or return) is signalled on the redirect inputs. It carries the new segment and pointer. The queue empties at once, fetching restarts at the new address, and any memory response that was still outstanding when the redirect came in is thrown away. Fetches from an odd pointer use only the upper byte lane of the returned word, so the fetch stream falls back onto word alignment straight after.

Top module: `pfq_unit`

## Requirements
- R1: While reset is asserted the byte queue is empty (`q_valid_o` low) and no memory request is raised (`mem_req_o` low). After reset, fetching begins at segment `RST_CS`, pointer `RST_IP`.
- R2: The fetch byte address is (segment × 16 + pointer) modulo 2^20. The pointer wraps modulo 2^16, so fetching past offset 0xFFFF continues at offset 0x0000 of the same segment.
- R3: The queue never holds more than 6 bytes. A word fetch starts only when at least 2 entries are free and the pointer is even. A single-byte fetch starts only when the pointer is odd and at least 1 entry is free.
- R4: A fetch from an odd address drives byte-lane enables `mem_be_o` = 2'b10 and queues only `mem_rdata_i[15:8]`. A fetch from an even address drives 2'b11 and queues `mem_rdata_i[7:0]` first, then `mem_rdata_i[15:8]`. The fetch after an odd fetch is at an even address.
- R5: Bytes leave the queue in ascending pointer order, one per cycle in which `q_valid_o` and `q_ready_i` are both high. Fetching continues while the consumer pops.
- R6: Once raised, `mem_req_o` stays high with `mem_addr_o` and `mem_be_o` unchanged until a cycle in which `mem_ack_i` is high.
- R7: A cycle with `jmp_valid_i` high empties the queue (`q_valid_o` low in the next cycle) and loads `jmp_cs_i`/`jmp_ip_i`. The first byte delivered afterwards is the byte at the new address.
- R8: When a redirect and a pop fall in the same cycle, the redirect wins. The presented byte is dropped along with the rest of the queue.
- R9: A memory response for a request that was outstanding at a redirect, or that arrives in the redirect cycle itself, is discarded and never reaches the queue.
- R10: With the consumer stalled and the queue unable to take another fetch, no memory request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| jmp_valid_i | input | 1 | Control transfer: flush and redirect |
| jmp_cs_i | input | 16 | New code segment |
| jmp_ip_i | input | 16 | New instruction pointer |
| mem_req_o | output | 1 | Fetch request, held until acknowledged |
| mem_addr_o | output | 20 | Byte address of the fetch |
| mem_be_o | output | 2 | Byte lanes wanted (bit 1 upper, bit 0 lower) |
| mem_ack_i | input | 1 | Request accepted, `mem_rdata_i` valid |
| mem_rdata_i | input | 16 | Word at the aligned address |
| q_valid_o | output | 1 | Queue head byte valid |
| q_byte_o | output | 8 | Queue head byte |
| q_ready_i | input | 1 | Consumer takes the head byte |

## Verification
The memory model derives each byte from its own 20-bit address, so any wrong address, lane choice or byte order shows up as a mismatch in the byte stream. The stream is tried with a consumer that is always ready, one that pops every other cycle and one that is fully stalled. The stalled case separates the even-start fill, which stops at six bytes, from the odd-start fill, which stops at five bytes with one entry still free. Redirects cover a segment-offset wrap and a sum beyond 2^20. A redirect colliding with a pop checks R8, and a redirect under slow memory, issued while a request is outstanding, shows that a stale word is discarded rather than queued.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    FK_WORD = 1'b0,
    FK_HIGH = 1'b1
  } fetch_kind_e;

  function automatic logic [1:0] kind_lanes(fetch_kind_e k);
    return (k == FK_HIGH) ? 2'b10 : 2'b11;
  endfunction
endpackage

// File: rtl/pfq_addr.sv
module pfq_addr #(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned SHIFT = 4,
  parameter int unsigned AW    = 20
) (
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [AW-1:0]    addr_o
);
  localparam int unsigned SW = SEG_W + SHIFT;
  logic [SW-1:0] base;

  always_comb begin
    base   = {seg_i, {SHIFT{1'b0}}};
    addr_o = AW'(base) + AW'(off_i);
  end
endmodule

// File: rtl/pfq_store.sv
module pfq_store #(
  parameter int unsigned DEPTH = 6,
  parameter int unsigned W     = 8,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush_i,
  input  logic [1:0]     push_n_i,
  input  logic [2*W-1:0] push_d_i,
  input  logic           pop_i,
  output logic [W-1:0]   head_o,
  output logic           valid_o,
  output logic [CW-1:0]  count_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW-1:0] rd_q, rd_n, wr_q, wr_n, wr1;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [W-1:0]  ent_q [DEPTH];

  function automatic logic [PW-1:0] step(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr1 = step(wr_q);
    if (flush_i) begin
      rd_n  = '0;
      wr_n  = '0;
      cnt_n = '0;
    end else begin
      rd_n  = pop_i ? step(rd_q) : rd_q;
      case (push_n_i)
        2'd1:    wr_n = wr1;
        2'd2:    wr_n = step(wr1);
        default: wr_n = wr_q;
      endcase
      cnt_n = cnt_q + CW'(push_n_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_n;
      wr_q  <= wr_n;
      cnt_q <= cnt_n;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic we_lo, we_hi;
    always_comb begin
      we_lo = !flush_i && (push_n_i != 2'd0) && (wr_q == PW'(g));
      we_hi = !flush_i && (push_n_i == 2'd2) && (wr1 == PW'(g));
    end
    always_ff @(posedge clk) begin
      if (we_lo)      ent_q[g] <= push_d_i[W-1:0];
      else if (we_hi) ent_q[g] <= push_d_i[2*W-1:W];
    end
  end

  always_comb begin
    head_o  = ent_q[rd_q];
    valid_o = (cnt_q != '0);
    count_o = cnt_q;
  end
endmodule

// File: rtl/pfq_unit.sv
module pfq_unit
  import pfq_pkg::*;
#(
  parameter int unsigned DEPTH  = 6,
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned IP_W   = 16,
  parameter int unsigned AW     = 20,
  parameter logic [15:0] RST_CS = 16'hFFFF,
  parameter logic [15:0] RST_IP = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              jmp_valid_i,
  input  logic [SEG_W-1:0]  jmp_cs_i,
  input  logic [IP_W-1:0]   jmp_ip_i,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [1:0]        mem_be_o,
  input  logic              mem_ack_i,
  input  logic [2*BYTE_W-1:0] mem_rdata_i,
  output logic              q_valid_o,
  output logic [BYTE_W-1:0] q_byte_o,
  input  logic              q_ready_i
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned DW = 2 * BYTE_W;

  logic [SEG_W-1:0] cs_q, cs_n;
  logic [IP_W-1:0]  ip_q, ip_n;
  logic             busy_q, busy_n, stale_q, stale_n;
  fetch_kind_e      kind_q, kind_n;
  logic [AW-1:0]    addr_q, addr_n, fetch_addr;
  logic [CW-1:0]    q_count, free;
  logic             flush, can_word, can_high, issue, accept, pop;
  logic [1:0]       push_n;
  logic [DW-1:0]    push_d;

  pfq_addr #(.SEG_W(SEG_W), .OFF_W(IP_W), .SHIFT(4), .AW(AW)) u_addr (
    .seg_i (cs_q),
    .off_i (ip_q),
    .addr_o(fetch_addr)
  );

  always_comb begin
    flush    = jmp_valid_i;
    free     = CW'(DEPTH) - q_count;
    can_word = !ip_q[0] && (free >= CW'(2));
    can_high =  ip_q[0] && (free >= CW'(1));
    issue    = !busy_q && !flush && (can_word || can_high);
    accept   = busy_q && mem_ack_i && !stale_q && !flush;
    pop      = q_valid_o && q_ready_i && !flush;

    cs_n   = flush ? jmp_cs_i : cs_q;
    ip_n   = flush ? jmp_ip_i
           : issue ? ip_q + {{(IP_W-2){1'b0}}, ~ip_q[0], ip_q[0]}
           : ip_q;
    kind_n = issue ? (ip_q[0] ? FK_HIGH : FK_WORD) : kind_q;
    addr_n = issue ? fetch_addr : addr_q;

    if (issue)                       busy_n = 1'b1;
    else if (busy_q && mem_ack_i)    busy_n = 1'b0;
    else                             busy_n = busy_q;

    if (busy_q && mem_ack_i)         stale_n = 1'b0;
    else if (busy_q && flush)        stale_n = 1'b1;
    else                             stale_n = stale_q;

    if (!accept) begin
      push_n = 2'd0;
      push_d = mem_rdata_i;
    end else if (kind_q == FK_HIGH) begin
      push_n = 2'd1;
      push_d = {mem_rdata_i[DW-1:BYTE_W], mem_rdata_i[DW-1:BYTE_W]};
    end else begin
      push_n = 2'd2;
      push_d = mem_rdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= RST_CS;
      ip_q    <= RST_IP;
      busy_q  <= 1'b0;
      stale_q <= 1'b0;
      kind_q  <= FK_WORD;
      addr_q  <= '0;
    end else begin
      cs_q    <= cs_n;
      ip_q    <= ip_n;
      busy_q  <= busy_n;
      stale_q <= stale_n;
      kind_q  <= kind_n;
      addr_q  <= addr_n;
    end
  end

  pfq_store #(.DEPTH(DEPTH), .W(BYTE_W), .CW(CW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (flush),
    .push_n_i(push_n),
    .push_d_i(push_d),
    .pop_i   (pop),
    .head_o  (q_byte_o),
    .valid_o (q_valid_o),
    .count_o (q_count)
  );

  always_comb begin
    mem_req_o  = busy_q;
    mem_addr_o = addr_q;
    mem_be_o   = kind_lanes(kind_q);
  end
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
  parameter int unsigned DEPTH = 6,
  parameter int unsigned AW    = 20,
  parameter int unsigned CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          jmp_valid_i,
  input logic          mem_req_o,
  input logic          mem_ack_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [1:0]    mem_be_o,
  input logic          q_valid_o,
  input logic [CW-1:0] q_count
);
  // R3: occupancy bound
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(DEPTH));

  // R6: request held steady until accepted
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_be_o));

  // R4: lane enables follow address parity
  p_lane_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (mem_be_o == (mem_addr_o[0] ? 2'b10 : 2'b11)));

  // R7: redirect empties the queue
  p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_valid_i |=> !q_valid_o);

  // R10: no fetch started while the queue is full
  p_full_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req_o && (q_count == CW'(DEPTH)) |=> !mem_req_o);
endmodule

bind pfq_unit pfq_checker #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_pfq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .jmp_valid_i(jmp_valid_i),
  .mem_req_o  (mem_req_o),
  .mem_ack_i  (mem_ack_i),
  .mem_addr_o (mem_addr_o),
  .mem_be_o   (mem_be_o),
  .q_valid_o  (q_valid_o),
  .q_count    (q_count)
);

// File: tb/test_pfq_unit.sv
module test_pfq_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] R_CS = 16'hFFFF;
  localparam logic [15:0] R_IP = 16'h0000;
  localparam int RUN_LEN = 96;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        jmp_valid_i;
  logic [15:0] jmp_cs_i, jmp_ip_i;
  logic        mem_req_o, mem_ack_i;
  logic [19:0] mem_addr_o;
  logic [1:0]  mem_be_o;
  logic [15:0] mem_rdata_i;
  logic        q_valid_o, q_ready_i;
  logic [7:0]  q_byte_o;

  int checks = 0;
  int errors = 0;
  int pops   = 0;
  int wcnt   = 0;
  bit slow   = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:0] new_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pfq_unit #(.RST_CS(R_CS), .RST_IP(R_IP)) i_pfq_unit (
    .clk(clk), .rst_n(rst_n),
    .jmp_valid_i(jmp_valid_i), .jmp_cs_i(jmp_cs_i), .jmp_ip_i(jmp_ip_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_be_o(mem_be_o),
    .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .q_valid_o(q_valid_o), .q_byte_o(q_byte_o), .q_ready_i(q_ready_i)
  );

  function automatic logic [7:0] mbyte(logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[11:8]};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver side: expected stream for a (segment, pointer) start
  task automatic fill_stream(logic [15:0] cs, logic [15:0] ip);
    new_q.delete();
    for (int i = 0; i < RUN_LEN; i++) begin
      logic [15:0] off;
      off = ip + 16'(i);
      new_q.push_back(mbyte({cs, 4'h0} + {4'h0, off}));
    end
  endtask

  // caller is at a falling edge
  task automatic jump(logic [15:0] cs, logic [15:0] ip);
    fill_stream(cs, ip);
    jmp_cs_i    = cs;
    jmp_ip_i    = ip;
    jmp_valid_i = 1'b1;
    @(negedge clk);
    jmp_valid_i = 1'b0;
  endtask

  task automatic run(int n, int mode);
    for (int i = 0; i < n; i++) begin
      case (mode)
        0: q_ready_i = 1'b1;
        1: q_ready_i = i[0];
        default: q_ready_i = 1'b0;
      endcase
      @(negedge clk);
    end
  endtask

  // memory model: word data derived from the address
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack_i   <= 1'b0;
      mem_rdata_i <= '0;
      wcnt        = 0;
    end else if (mem_req_o && !mem_ack_i) begin
      if (wcnt >= (slow ? 4 : int'(mem_addr_o[2:1]))) begin
        mem_ack_i   <= 1'b1;
        mem_rdata_i <= {mbyte({mem_addr_o[19:1], 1'b1}), mbyte({mem_addr_o[19:1], 1'b0})};
        wcnt        = 0;
        check(mem_be_o == (mem_addr_o[0] ? 2'b10 : 2'b11), "R4 lane enables",
              32'(mem_be_o), 32'(mem_addr_o[0] ? 2'b10 : 2'b11));
      end else begin
        wcnt++;
      end
    end else begin
      mem_ack_i <= 1'b0;
    end
  end

  // monitor / scoreboard
  always begin
    @(negedge clk);
    #(CLK_PERIOD/2 - 1);
    if (rst_n) begin
      if (jmp_valid_i) begin
        exp_q = new_q;           // R8: a pop in this cycle is dropped
      end else if (q_valid_o && q_ready_i) begin
        pops++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected byte", 32'(q_byte_o), 32'h0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(q_byte_o == e, "R5 R2 byte stream", 32'(q_byte_o), 32'(e));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p0;
    rst_n = 1'b0; jmp_valid_i = 1'b0; jmp_cs_i = '0; jmp_ip_i = '0; q_ready_i = 1'b0;
    fill_stream(R_CS, R_IP);
    exp_q = new_q;
    repeat (3) @(negedge clk);
    #1;
    check(!q_valid_o, "R1 queue empty in reset", 32'(q_valid_o), 0);
    check(!mem_req_o, "R1 no request in reset", 32'(mem_req_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: stalled consumer, even start fills to six and stops
    run(30, 2);
    check(!mem_req_o, "R10 idle when full", 32'(mem_req_o), 0);
    check(q_valid_o, "R5 data queued", 32'(q_valid_o), 1);
    p0 = pops; run(24, 0);
    check(pops - p0 >= 12, "R5 pops with concurrent fetch", 32'(pops - p0), 12);

    // R2 R4: odd start near the end of the segment offset range
    jump(16'h1000, 16'hFFFD);
    p0 = pops; run(40, 1);
    check(pops - p0 >= 10, "R2 wrap stream delivered", 32'(pops - p0), 10);

    // R3: odd start with a stalled consumer stops at five bytes
    jump(16'hFFFF, 16'h0021);
    run(30, 2);
    check(!mem_req_o, "R3 no word fetch with one free entry", 32'(mem_req_o), 0);
    p0 = pops; run(20, 0);
    check(pops - p0 >= 5, "R3 R2 stream after 20-bit wrap", 32'(pops - p0), 5);

    // R8: redirect collides with a pop
    q_ready_i = 1'b1;
    while (!q_valid_o) @(negedge clk);
    check(q_valid_o && q_ready_i, "R8 pop and redirect together", 32'(q_valid_o), 1);
    jump(16'h2345, 16'h0100);
    check(!q_valid_o, "R8 R7 queue emptied", 32'(q_valid_o), 0);
    p0 = pops; run(20, 0);
    check(pops - p0 >= 5, "R7 new stream delivered", 32'(pops - p0), 5);

    // R9: redirect while a slow request is outstanding
    slow = 1'b1;
    while (!mem_req_o) @(negedge clk);
    jump(16'h0ABC, 16'h0007);
    while (mem_req_o) @(negedge clk);
    check(!q_valid_o, "R9 stale response dropped", 32'(q_valid_o), 0);
    p0 = pops; run(40, 0);
    check(pops - p0 >= 5, "R9 fresh stream after drop", 32'(pops - p0), 5);

    run(4, 2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule